// File: doc/BRIEF.md
# Spare Row and Column-Group Remapping Wrapper

This block sits between a system-side synchronous memory port and a main memory array, and holds a small spare memory of its own. It has two kinds of spare element. A spare row replaces every word of one main-memory row. A spare column group replaces one 4-bit subword lane at one column address, in every row. After reset the redundancy analysis logic, which lies outside this block, writes repair records through a load port. It then pulses a done strobe that arms the wrapper.

Once the wrapper is armed, each access compares its row and column address with the stored records. The wrapper drives a per-lane mask to the main array. A row repair masks the whole word and blocks the main write. A column-group repair masks only its own lane, and the main write of the other lanes goes ahead. Writes go to the matching spare in parallel. On the read side, the registered hit information steers the spare outputs into the word in the same cycle that the main array delivers its data.

Top module: `mrr_remap_wrap`

## Requirements
- R1: After reset no record is valid and the wrapper is unarmed: arr_mask is 0, arr_we equals sys_we, arr_addr and arr_wdata equal sys_addr and sys_wdata, and sys_rdata equals arr_rdata.
- R2: Records written through the load port (ld_kind 0 = spare row record holding ld_row, 1 = column-group record holding ld_col and ld_lane, slot chosen by ld_idx) take no effect until ld_done has been seen; until then every access passes straight through as in R1.
- R3: When armed, an access whose row address (sys_addr bits [4:2]) matches a valid row record drives arr_mask to all ones and arr_we to 0. A write stores the full word in that spare row at the column sys_addr[1:0], and a read returns the full spare word.
- R4: A row-record match takes priority over any column-group match: the returned word comes wholly from the spare row, with no lane taken from a column group.
- R5: When armed and no row record matches, an access whose column address (sys_addr[1:0]) matches a valid column-group record sets only arr_mask bit L (bit L masks data bits [4L+3:4L]) and leaves arr_we equal to sys_we. A write stores that lane in the group's spare at the access row. The read returns the main word with lane L replaced from the spare.
- R6: Two column-group records on the same column with different lanes both apply to one access: both mask bits are set and both lanes are merged.
- R7: Read data of an access issued in one cycle is on sys_rdata in the next cycle, in the same cycle as arr_rdata. A read that coincides with a write returns the content from before that write.
- R8: Once armed, the load port is ignored until the next reset, so a record loaded after ld_done does not redirect accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears records and arm state |
| ld_we | input | 1 | Record load strobe |
| ld_kind | input | 1 | 0 = spare row record, 1 = column-group record |
| ld_idx | input | 2 | Record slot number |
| ld_row | input | 3 | Faulty row address for a row record |
| ld_col | input | 2 | Faulty column address for a column-group record |
| ld_lane | input | 2 | Faulty subword lane for a column-group record |
| ld_done | input | 1 | Arms the wrapper after loading |
| sys_addr | input | 5 | System address {row, column} |
| sys_we | input | 1 | System write enable |
| sys_wdata | input | 16 | System write data |
| sys_rdata | output | 16 | Repaired read data, one cycle after the address |
| arr_addr | output | 5 | Main array address |
| arr_we | output | 1 | Main array write enable |
| arr_wdata | output | 16 | Main array write data |
| arr_mask | output | 4 | Per-lane mask; a set bit suppresses that lane of the main array |
| arr_rdata | input | 16 | Main array read data, one cycle after the address |

## Verification
The assertions assume that the analysis logic never loads two row records with the same row, and never loads two column-group records with the same column and lane. Under that assumption at most one spare row matches, and the count of mask bits equals the count of group hits. The bench loads distinct rows (5 and 2) and two groups on column 1 in lanes 2 and 0. It keeps the load port quiet while ld_done is asserted, except for one deliberately ignored load made after arming. The external array is modelled read-first with per-lane write masking, which is the behaviour the read-path checks rely on.

// File: rtl/mrr_pkg.sv
package mrr_pkg;
  typedef enum logic {
    REC_ROW = 1'b0,
    REC_COL = 1'b1
  } rec_kind_e;
endpackage

// File: rtl/mrr_record_table.sv
module mrr_record_table
  import mrr_pkg::*;
#(
  parameter int ROW_W = 3,
  parameter int COL_W = 2,
  parameter int LN_W  = 2,
  parameter int IDX_W = 2,
  parameter int N_SR  = 4,
  parameter int N_CG  = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ld_we,
  input  logic                   ld_kind,
  input  logic [IDX_W-1:0]       ld_idx,
  input  logic [ROW_W-1:0]       ld_row,
  input  logic [COL_W-1:0]       ld_col,
  input  logic [LN_W-1:0]        ld_lane,
  input  logic                   ld_done,
  input  logic [ROW_W-1:0]       acc_row,
  input  logic [COL_W-1:0]       acc_col,
  output logic                   armed,
  output logic [N_SR-1:0]        row_hit,
  output logic [N_CG-1:0]        col_hit,
  output logic [N_CG*LN_W-1:0]   col_lane_flat
);

  logic                          ld_open;
  logic [N_SR-1:0]               sr_vld;
  logic [N_SR-1:0][ROW_W-1:0]    sr_row;
  logic [N_CG-1:0]               cg_vld;
  logic [N_CG-1:0][COL_W-1:0]    cg_col;
  logic [N_CG-1:0][LN_W-1:0]     cg_lane;

  assign ld_open = ld_we & ~armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (ld_done) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_vld <= '0;
      sr_row <= '0;
    end else begin
      for (int r = 0; r < N_SR; r++) begin
        if (ld_open && rec_kind_e'(ld_kind) == REC_ROW && ld_idx == IDX_W'(r)) begin
          sr_vld[r] <= 1'b1;
          sr_row[r] <= ld_row;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cg_vld  <= '0;
      cg_col  <= '0;
      cg_lane <= '0;
    end else begin
      for (int g = 0; g < N_CG; g++) begin
        if (ld_open && rec_kind_e'(ld_kind) == REC_COL && ld_idx == IDX_W'(g)) begin
          cg_vld[g]  <= 1'b1;
          cg_col[g]  <= ld_col;
          cg_lane[g] <= ld_lane;
        end
      end
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_SR; gi++) begin : g_row_cmp
      assign row_hit[gi] = armed & sr_vld[gi] & (sr_row[gi] == acc_row);
    end
    for (gi = 0; gi < N_CG; gi++) begin : g_col_cmp
      assign col_hit[gi] = armed & cg_vld[gi] & (cg_col[gi] == acc_col);
      assign col_lane_flat[gi*LN_W +: LN_W] = cg_lane[gi];
    end
  endgenerate

  AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed); // R2

  AST_RECORDS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> ($stable(sr_vld) && $stable(sr_row) && $stable(cg_vld) && $stable(cg_col))); // R8

  AST_UNARMED_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (row_hit == '0 && col_hit == '0)); // R2

endmodule

// File: rtl/mrr_spare_store.sv
module mrr_spare_store #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2,
  parameter int LANE_W = 4,
  parameter int LANES  = 4,
  parameter int LN_W   = 2,
  parameter int N_SR   = 4,
  parameter int N_CG   = 2,
  parameter int SRI_W  = 2
) (
  input  logic                      clk,
  input  logic                      row_wr,
  input  logic [SRI_W-1:0]          row_sel,
  input  logic [ROW_W-1:0]          acc_row,
  input  logic [COL_W-1:0]          acc_col,
  input  logic [LANE_W*LANES-1:0]   wdata,
  input  logic [N_CG-1:0]           cg_wr,
  input  logic [N_CG*LN_W-1:0]      cg_lane_flat,
  output logic [LANE_W*LANES-1:0]   row_q,
  output logic [N_CG*LANE_W-1:0]    cg_q_flat
);

  localparam int DATA_W   = LANE_W * LANES;
  localparam int ROW_SPAN = 1 << COL_W;
  localparam int SR_DEPTH = N_SR * ROW_SPAN;
  localparam int CG_DEPTH = 1 << ROW_W;

  function automatic logic [LANE_W-1:0] pick_lane(input logic [DATA_W-1:0] word,
                                                  input logic [LN_W-1:0] lane);
    return word[lane*LANE_W +: LANE_W];
  endfunction

  function automatic int row_slot(input logic [SRI_W-1:0] sel, input logic [COL_W-1:0] col);
    return int'(sel) * ROW_SPAN + int'(col);
  endfunction

  logic [DATA_W-1:0] row_mem [SR_DEPTH];

  always_ff @(posedge clk) begin
    row_q <= row_mem[row_slot(row_sel, acc_col)];
    if (row_wr) row_mem[row_slot(row_sel, acc_col)] <= wdata;
  end

  genvar g;
  generate
    for (g = 0; g < N_CG; g++) begin : g_colgrp
      logic [LANE_W-1:0] grp_mem [CG_DEPTH];
      logic [LN_W-1:0]   my_lane;
      assign my_lane = cg_lane_flat[g*LN_W +: LN_W];
      always_ff @(posedge clk) begin
        cg_q_flat[g*LANE_W +: LANE_W] <= grp_mem[acc_row];
        if (cg_wr[g]) grp_mem[acc_row] <= pick_lane(wdata, my_lane);
      end
    end
  endgenerate

endmodule

// File: rtl/mrr_remap_wrap.sv
module mrr_remap_wrap #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 2,
  parameter int LANE_W = 4,
  parameter int LANES  = 4,
  parameter int N_SR   = 4,
  parameter int N_CG   = 2,
  parameter int LN_W   = (LANES > 1) ? $clog2(LANES) : 1,
  parameter int IDX_W  = ((N_SR > N_CG ? N_SR : N_CG) > 1) ? $clog2(N_SR > N_CG ? N_SR : N_CG) : 1,
  parameter int ADDR_W = ROW_W + COL_W,
  parameter int DATA_W = LANE_W * LANES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ld_we,
  input  logic               ld_kind,
  input  logic [IDX_W-1:0]   ld_idx,
  input  logic [ROW_W-1:0]   ld_row,
  input  logic [COL_W-1:0]   ld_col,
  input  logic [LN_W-1:0]    ld_lane,
  input  logic               ld_done,
  input  logic [ADDR_W-1:0]  sys_addr,
  input  logic               sys_we,
  input  logic [DATA_W-1:0]  sys_wdata,
  output logic [DATA_W-1:0]  sys_rdata,
  output logic [ADDR_W-1:0]  arr_addr,
  output logic               arr_we,
  output logic [DATA_W-1:0]  arr_wdata,
  output logic [LANES-1:0]   arr_mask,
  input  logic [DATA_W-1:0]  arr_rdata
);

  localparam int SRI_W = (N_SR > 1) ? $clog2(N_SR) : 1;

  // Index of the lowest set bit of the row-hit vector.
  function automatic logic [SRI_W-1:0] first_hit(input logic [N_SR-1:0] hits);
    logic [SRI_W-1:0] idx;
    idx = '0;
    for (int r = N_SR - 1; r >= 0; r--) if (hits[r]) idx = SRI_W'(r);
    return idx;
  endfunction

  // Lane mask produced by the column-group hits.
  function automatic logic [LANES-1:0] lanes_of(input logic [N_CG-1:0] hits,
                                                input logic [N_CG*LN_W-1:0] lanes);
    logic [LANES-1:0] m;
    m = '0;
    for (int g = 0; g < N_CG; g++)
      if (hits[g]) m[lanes[g*LN_W +: LN_W]] = 1'b1;
    return m;
  endfunction

  // Replace the hit lanes of a main word with spare column-group data.
  function automatic logic [DATA_W-1:0] merge_lanes(input logic [DATA_W-1:0] base,
                                                    input logic [N_CG-1:0] hits,
                                                    input logic [N_CG*LN_W-1:0] lanes,
                                                    input logic [N_CG*LANE_W-1:0] spare);
    logic [DATA_W-1:0] w;
    w = base;
    for (int g = N_CG - 1; g >= 0; g--)
      if (hits[g]) w[lanes[g*LN_W +: LN_W]*LANE_W +: LANE_W] = spare[g*LANE_W +: LANE_W];
    return w;
  endfunction

  logic [ROW_W-1:0]        acc_row;
  logic [COL_W-1:0]        acc_col;
  logic                    armed;
  logic [N_SR-1:0]         row_hit;
  logic [N_CG-1:0]         col_hit;
  logic [N_CG*LN_W-1:0]    col_lane_flat;
  logic                    row_any;
  logic [SRI_W-1:0]        row_sel;
  logic                    row_wr;
  logic [N_CG-1:0]         cg_wr;
  logic [DATA_W-1:0]       row_q;
  logic [N_CG*LANE_W-1:0]  cg_q_flat;
  logic                    q_row_any;
  logic [N_CG-1:0]         q_col_hit;
  logic [N_CG*LN_W-1:0]    q_col_lane;

  assign acc_row = sys_addr[ADDR_W-1:COL_W];
  assign acc_col = sys_addr[COL_W-1:0];

  mrr_record_table #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LN_W(LN_W), .IDX_W(IDX_W), .N_SR(N_SR), .N_CG(N_CG)
  ) u_table (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_kind(ld_kind), .ld_idx(ld_idx),
    .ld_row(ld_row), .ld_col(ld_col), .ld_lane(ld_lane), .ld_done(ld_done),
    .acc_row(acc_row), .acc_col(acc_col), .armed(armed), .row_hit(row_hit),
    .col_hit(col_hit), .col_lane_flat(col_lane_flat)
  );

  assign row_any  = |row_hit;
  assign row_sel  = first_hit(row_hit);
  assign row_wr   = sys_we & row_any;
  assign cg_wr    = col_hit & {N_CG{sys_we & ~row_any}};

  assign arr_addr  = sys_addr;
  assign arr_wdata = sys_wdata;
  assign arr_we    = sys_we & ~row_any;
  assign arr_mask  = row_any ? {LANES{1'b1}} : lanes_of(col_hit, col_lane_flat);

  mrr_spare_store #(
    .ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(LANE_W), .LANES(LANES), .LN_W(LN_W),
    .N_SR(N_SR), .N_CG(N_CG), .SRI_W(SRI_W)
  ) u_store (
    .clk(clk), .row_wr(row_wr), .row_sel(row_sel), .acc_row(acc_row), .acc_col(acc_col),
    .wdata(sys_wdata), .cg_wr(cg_wr), .cg_lane_flat(col_lane_flat),
    .row_q(row_q), .cg_q_flat(cg_q_flat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_row_any  <= 1'b0;
      q_col_hit  <= '0;
      q_col_lane <= '0;
    end else begin
      q_row_any  <= row_any;
      q_col_hit  <= col_hit;
      q_col_lane <= col_lane_flat;
    end
  end

  assign sys_rdata = q_row_any ? row_q
                               : merge_lanes(arr_rdata, q_col_hit, q_col_lane, cg_q_flat);

  AST_UNARMED_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (arr_mask == '0 && arr_we == sys_we)); // R2

  AST_ROW_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_we && row_any) |-> !arr_we); // R3

  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(row_hit)); // R3

  AST_ROW_READ_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
    row_any |=> (sys_rdata == row_q)); // R4

  AST_COL_KEEPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_any && col_hit != '0) |-> (arr_we == sys_we && $countones(arr_mask) == $countones(col_hit))); // R6

  AST_CLEAN_READ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!row_any && col_hit == '0) |=> (sys_rdata == arr_rdata)); // R7

endmodule

// File: tb/mrr_remap_wrap_test.sv
`timescale 1ns/1ps
module mrr_remap_wrap_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0, ld_kind = 1'b0, ld_done = 1'b0;
  logic [1:0]  ld_idx = '0, ld_col = '0, ld_lane = '0;
  logic [2:0]  ld_row = '0;
  logic [4:0]  sys_addr = '0;
  logic        sys_we = 1'b0;
  logic [15:0] sys_wdata = '0;
  logic [15:0] sys_rdata;
  logic [4:0]  arr_addr;
  logic        arr_we;
  logic [15:0] arr_wdata;
  logic [3:0]  arr_mask;
  logic [15:0] arr_rdata = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mrr_remap_wrap uut (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_kind(ld_kind), .ld_idx(ld_idx),
    .ld_row(ld_row), .ld_col(ld_col), .ld_lane(ld_lane), .ld_done(ld_done),
    .sys_addr(sys_addr), .sys_we(sys_we), .sys_wdata(sys_wdata), .sys_rdata(sys_rdata),
    .arr_addr(arr_addr), .arr_we(arr_we), .arr_wdata(arr_wdata), .arr_mask(arr_mask),
    .arr_rdata(arr_rdata)
  );

  // Main array with defective cells: stuck-at-0 bits per address, read-first, lane masked writes.
  logic [15:0] main_mem [32];
  initial for (int i = 0; i < 32; i++) main_mem[i] = 16'h0000;

  function automatic logic [15:0] stuck_bits(input logic [4:0] a);
    if (a[4:2] == 3'd5) return 16'h0F0F;
    if (a[4:2] == 3'd2) return 16'hF000;
    if (a[4:2] == 3'd3 && a[1:0] == 2'd1) return 16'h0F00;
    if (a[4:2] == 3'd6 && a[1:0] == 2'd1) return 16'h000F;
    return 16'h0000;
  endfunction

  always @(posedge clk) begin
    arr_rdata <= main_mem[arr_addr] & ~stuck_bits(arr_addr);
    if (arr_we)
      for (int l = 0; l < 4; l++)
        if (!arr_mask[l]) main_mem[arr_addr][l*4 +: 4] <= arr_wdata[l*4 +: 4];
  end

  // Reference: an ideal memory the repaired wrapper must imitate once armed.
  bit          armed_m = 1'b0;
  logic [15:0] ideal [32];
  bit          ideal_v [32];
  bit          pend = 1'b0;
  bit          pend_pass = 1'b0;
  logic [15:0] pend_exp = '0;
  string       pend_tag = "";

  function automatic bit is_row_rep(input logic [4:0] a);
    return armed_m && (a[4:2] == 3'd5 || a[4:2] == 3'd2);
  endfunction

  function automatic logic [3:0] exp_mask(input logic [4:0] a);
    if (!armed_m) return 4'b0000;
    if (is_row_rep(a)) return 4'b1111;
    if (a[1:0] == 2'd1) return 4'b0101;   // groups on column 1, lanes 2 and 0
    return 4'b0000;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_pending();
    if (pend) begin
      if (pend_pass) chk(sys_rdata == arr_rdata, pend_tag, 32'(sys_rdata), 32'(arr_rdata));
      else           chk(sys_rdata == pend_exp, pend_tag, 32'(sys_rdata), 32'(pend_exp));
    end
    pend = 1'b0;
  endtask

  task automatic access(input bit we, input logic [4:0] a, input logic [15:0] d);
    string mtag;
    logic [3:0] em;
    @(negedge clk);
    check_pending();
    sys_we = we; sys_addr = a; sys_wdata = d;
    #1;
    em = exp_mask(a);
    if (!armed_m) mtag = "R2 mask pass-through";
    else if (em == 4'b1111) mtag = "R3 row mask";
    else if (em != 4'b0000) mtag = "R6 two-lane mask";
    else mtag = "R7 clean mask";
    chk(arr_mask == em, mtag, 32'(arr_mask), 32'(em));
    chk(arr_we == (we && em != 4'b1111), {mtag, " we"}, 32'(arr_we), 32'(we && em != 4'b1111));
    chk(arr_addr == a && arr_wdata == d, "R1 addr/data forward", 32'({arr_addr, arr_wdata}), 32'({a, d}));
    if (!armed_m) begin
      pend = 1'b1; pend_pass = 1'b1; pend_tag = "R2 read pass-through";
    end else if (ideal_v[a]) begin
      pend = 1'b1; pend_pass = 1'b0; pend_exp = ideal[a];
      if (is_row_rep(a) && a[1:0] == 2'd1) pend_tag = "R4 row over column";
      else if (is_row_rep(a)) pend_tag = "R3 spare row read";
      else if (a[1:0] == 2'd1) pend_tag = "R5 column-group read";
      else pend_tag = "R7 plain read";
    end
    if (we && armed_m) begin
      ideal[a] = d;
      ideal_v[a] = 1'b1;
    end
  endtask

  task automatic load(input bit kind, input logic [1:0] idx, input logic [2:0] row,
                      input logic [1:0] col, input logic [1:0] lane);
    @(negedge clk);
    ld_we = 1'b1; ld_kind = kind; ld_idx = idx; ld_row = row; ld_col = col; ld_lane = lane;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int i = 0; i < 32; i++) ideal_v[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state, no redirection
    chk(arr_mask == 4'b0000, "R1 reset mask", 32'(arr_mask), 32'h0);
    access(1'b1, 5'd21, 16'hAAAA);
    access(1'b0, 5'd21, 16'h0);
    access(1'b0, 5'd4, 16'h0);
    // R2: records loaded but not armed: still pass-through
    load(1'b0, 2'd0, 3'd5, 2'd0, 2'd0);
    load(1'b0, 2'd1, 3'd2, 2'd0, 2'd0);
    load(1'b1, 2'd0, 3'd0, 2'd1, 2'd2);
    load(1'b1, 2'd1, 3'd0, 2'd1, 2'd0);
    access(1'b1, 5'd13, 16'h1234);
    access(1'b0, 5'd13, 16'h0);
    access(1'b0, 5'd21, 16'h0);
    access(1'b1, 5'd9, 16'hFFFF);
    access(1'b0, 5'd9, 16'h0);
    @(negedge clk);
    check_pending();
    ld_done = 1'b1;
    @(negedge clk);
    ld_done = 1'b0;
    armed_m = 1'b1;
    // R8: a load after arming must not redirect row 1
    load(1'b0, 2'd3, 3'd1, 2'd0, 2'd0);
    // Sweep writes then reads over the whole space
    for (int i = 0; i < 32; i++) access(1'b1, 5'(i), 16'(i * 16'h0911 + 16'h5A3C));
    for (int i = 0; i < 32; i++) access(1'b0, 5'(i), 16'h0);
    for (int i = 4; i < 8; i++) access(1'b1, 5'(i), 16'hFFFF);
    for (int i = 4; i < 8; i++) access(1'b0, 5'(i), 16'h0);
    // Same-address write then read back-to-back (read-first, R7)
    access(1'b1, 5'd13, 16'hBEEF);
    access(1'b1, 5'd13, 16'hC0DE);
    access(1'b0, 5'd13, 16'h0);
    access(1'b1, 5'd21, 16'h7777);
    access(1'b0, 5'd21, 16'h0);
    // Pseudo-random traffic
    seed = 32'h1ACE_2B3D;
    for (int n = 0; n < 600; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      access(seed[20], seed[28:24], seed[19:4]);
    end
    access(1'b0, 5'd0, 16'h0);
    @(negedge clk);
    check_pending();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule